// File: doc/BRIEF.md
# Auto-Reload PWM Timer

This block is a single-channel pulse-width timer built around an up-counter that runs from a programmable start value to all-ones. When the counter wraps, it reloads from a load register and the output becomes active. When the counter equals a match register, the output returns to its inactive level. The period is therefore set by how far the load value sits below all-ones, and the duty by how far the match value sits above the load value.

Software drives the block through a single write port. The port has four targets: load, match, counter and control. The control word holds the run bit, the output inversion bit and a two-bit output mode. Starting the timer presets the counter to one below all-ones, so the first wrap, and with it the first active edge, comes two cycles after the start. Stopping the timer freezes the counter at once. A status word reports the run and inversion bits, and the counter value is visible on its own output.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the counter reads 0, the output is low and the status word is 0 (stopped, normal polarity, output mode off).
- R2: A write with wr_sel=2 loads the counter with wr_data on the next cycle while the timer is stopped, and is ignored while the timer runs.
- R3: A control write (wr_sel=3) that sets bit 0 while the timer is stopped starts the timer. The counter then reads all-ones minus 1 in the next cycle and all-ones in the one after. The first reload, and the first active output, follow in the cycle after that.
- R4: While running, the counter increments by one each cycle. From all-ones it reloads the value of the load register (wr_sel=0).
- R5: In set/clear mode (control bits 3:2 = 2 or 3), the output is active while the counter lies between the load value and the match value (wr_sel=1), both included. It is inactive for the rest of the period, so it is active for match−load+1 cycles and inactive for all-ones−match cycles.
- R6: When the match value equals all-ones, so that match and wrap fall on the same cycle, the wrap wins. The output stays active.
- R7: In toggle mode (control bits 3:2 = 1), the output inverts on every wrap, and matches have no effect.
- R8: In off mode (control bits 3:2 = 0), the output stays at its inactive level while the counter runs.
- R9: Control bit 1 inverts the output. While the timer is stopped, the output equals this bit.
- R10: A control write made while the timer runs changes only the run bit. The inversion and mode fields keep their values.
- R11: A control write that clears bit 0 stops the counter in the same cycle, with no further increment, and drives the output inactive. A stopped counter holds its value.
- R12: A load write made while the timer runs takes effect at the next wrap. A match write is used for comparison from the following cycle onward.
- R13: status_o bit 0 is the run bit and bit 1 is the inversion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 load, 1 match, 2 counter, 3 control |
| wr_data_i | input | CNT_W | Write data; control uses bit 0 run, bit 1 invert, bits 3:2 mode |
| pwm_o | output | 1 | Pulse-width output |
| count_o | output | CNT_W | Current counter value |
| status_o | output | 2 | {invert, run} |

## Verification
A corrupt counter shows up on count_o in the very next cycle, because the count must step by one or reload exactly at all-ones. A wrong output level shows on pwm_o in the cycle where the counter crosses the load or match value. A missed or extra wrap shows on both ports within one period. A control field that is overwritten while the timer runs shows on status_o at once, and on the output level from the next cycle. A counter that keeps moving after a stop shows on count_o one cycle after the stop write.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_MATCH = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_TOGGLE  = 2'd1,
    MODE_SETCLR  = 2'd2,
    MODE_SETCLR2 = 2'd3
  } tmode_e;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_INV_BIT  = 1;
  localparam int CTL_MODE_LSB = 2;
  localparam int STAT_W       = 2;

  typedef struct packed {
    logic   run;
    logic   inv;
    tmode_e mode;
  } ctl_t;
endpackage

// File: rtl/pwm_tmr_rst_sync.sv
module pwm_tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] match_q,
  output ctl_t             ctl_q,
  output logic             run_d,
  output logic             start_p,
  output logic             cnt_wr
);
  logic load_en, match_en, ctl_en;
  ctl_t ctl_d;

  always_comb begin
    load_en  = wr_en_i && (wr_sel_i == SEL_LOAD);
    match_en = wr_en_i && (wr_sel_i == SEL_MATCH);
    ctl_en   = wr_en_i && (wr_sel_i == SEL_CTRL);
    ctl_d    = ctl_q;
    if (ctl_en) begin
      ctl_d.run = wr_data_i[CTL_RUN_BIT];
      // inversion and mode are frozen while the counter runs
      if (!ctl_q.run) begin
        ctl_d.inv  = wr_data_i[CTL_INV_BIT];
        ctl_d.mode = tmode_e'(wr_data_i[CTL_MODE_LSB +: 2]);
      end
    end
    run_d   = ctl_d.run;
    start_p = ctl_d.run && !ctl_q.run;
    cnt_wr  = wr_en_i && (wr_sel_i == SEL_COUNT) && !ctl_q.run;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q  <= '0;
      match_q <= '0;
      ctl_q   <= '{run: 1'b0, inv: 1'b0, mode: MODE_OFF};
    end else begin
      if (load_en)  load_q  <= wr_data_i;
      if (match_en) match_q <= wr_data_i;
      if (ctl_en)   ctl_q   <= ctl_d;
    end
  end
endmodule

// File: rtl/pwm_tmr_count.sv
module pwm_tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_q,
  input  logic             run_d,
  input  logic             start_p,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] load_q,
  input  logic [CNT_W-1:0] match_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ALL1 = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] PRE  = ALL1 - ONE;

  logic             cnt_en, cnt_upd;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    // counting stops on the same edge that clears the run bit
    cnt_en  = run_q && run_d;
    ovf     = cnt_en && (cnt_q == ALL1);
    hit     = cnt_en && (cnt_q == match_q);
    cnt_upd = start_p || cnt_wr || cnt_en;
    cnt_d   = cnt_q;
    if (start_p)     cnt_d = PRE;
    else if (cnt_wr) cnt_d = wr_data_i;
    else if (ovf)    cnt_d = load_q;
    else if (cnt_en) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave
  import pwm_tmr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_d,
  input  logic   start_p,
  input  tmode_e mode,
  input  logic   inv,
  input  logic   ovf,
  input  logic   hit,
  output logic   pwm_o
);
  logic raw_q, raw_d;

  always_comb begin
    raw_d = raw_q;
    if (!run_d || start_p) begin
      raw_d = 1'b0;
    end else begin
      unique case (mode)
        MODE_OFF:    raw_d = 1'b0;
        MODE_TOGGLE: if (ovf) raw_d = !raw_q;
        default: begin
          // wrap outranks match when both fall on one cycle
          if (ovf)      raw_d = 1'b1;
          else if (hit) raw_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= raw_d;
  end

  assign pwm_o = raw_q ^ inv;
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              pwm_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [STAT_W-1:0] status_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] load_q, match_q, cnt_q;
  ctl_t             ctl_q;
  logic             run_d, start_p, cnt_wr, ovf, hit;

  pwm_tmr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  pwm_tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .load_q   (load_q),
    .match_q  (match_q),
    .ctl_q    (ctl_q),
    .run_d    (run_d),
    .start_p  (start_p),
    .cnt_wr   (cnt_wr)
  );

  pwm_tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .run_q    (ctl_q.run),
    .run_d    (run_d),
    .start_p  (start_p),
    .cnt_wr   (cnt_wr),
    .wr_data_i(wr_data_i),
    .load_q   (load_q),
    .match_q  (match_q),
    .cnt_q    (cnt_q),
    .ovf      (ovf),
    .hit      (hit)
  );

  pwm_tmr_wave u_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .run_d  (run_d),
    .start_p(start_p),
    .mode   (ctl_q.mode),
    .inv    (ctl_q.inv),
    .ovf    (ovf),
    .hit    (hit),
    .pwm_o  (pwm_o)
  );

  assign count_o  = cnt_q;
  assign status_o = {ctl_q.inv, ctl_q.run};
endmodule

// File: rtl/pwm_reload_timer_chk.sv
module pwm_reload_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic             run_q,
  input logic             inv_q,
  input logic [1:0]       mode_q,
  input logic             pwm_o
);
  localparam logic [CNT_W-1:0] ALL1 = '1;
  localparam logic [CNT_W-1:0] PRE  = ALL1 - {{(CNT_W-1){1'b0}}, 1'b1};

  logic ctl_wr;
  assign ctl_wr = wr_en_i && (wr_sel_i == 2'd3);

  a_r2_cnt_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run_q && wr_en_i && wr_sel_i == 2'd2) |=> cnt_q == $past(wr_data_i));

  a_r3_preload: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run_q && ctl_wr && wr_data_i[0]) |=> cnt_q == PRE);

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_q && cnt_q == ALL1 && !ctl_wr) |=> cnt_q == $past(load_q));

  a_r6_wrap_wins: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_q && mode_q[1] && cnt_q == ALL1 && !ctl_wr) |=> pwm_o != inv_q);

  a_r9_idle_level: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run_q |-> pwm_o == inv_q);

  a_r10_inv_locked: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_q && ctl_wr && wr_data_i[0]) |=> inv_q == $past(inv_q));

  a_r11_stop_freeze: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_q && ctl_wr && !wr_data_i[0]) |=> cnt_q == $past(cnt_q));

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run_q && !wr_en_i) |=> cnt_q == $past(cnt_q));
endmodule

bind pwm_reload_timer pwm_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_sync_n),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .wr_data_i(wr_data_i),
  .cnt_q    (cnt_q),
  .load_q   (load_q),
  .run_q    (ctl_q.run),
  .inv_q    (ctl_q.inv),
  .mode_q   (ctl_q.mode),
  .pwm_o    (pwm_o)
);

// File: tb/pwm_reload_timer_tb.sv
module pwm_reload_timer_tb;
  localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        pwm;
  logic [31:0] cnt;
  logic [1:0]  status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_reload_timer #(.CNT_W(32), .RST_STAGES(2)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_data_i(wr_data),
    .pwm_o    (pwm),
    .count_o  (cnt),
    .status_o (status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // set/clear waveform follow-up: next count from last one, level from range
  task automatic check_sc(input int n, input logic [31:0] ld, input logic [31:0] mt, input logic iv);
    for (int i = 0; i < n; i++) begin
      logic [31:0] prev, exp_c;
      prev = cnt;
      @(negedge clk);
      exp_c = (prev == ALL1) ? ld : prev + 32'd1;
      check("R4 count step", cnt, exp_c);
      check("R5 level", {31'd0, pwm}, {31'd0, ((cnt >= ld && cnt <= mt) ? 1'b1 : 1'b0) ^ iv});
    end
  endtask

  task automatic poll(input logic [31:0] val);
    for (int k = 0; k < 40 && cnt != val; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 count", cnt, 32'd0);
    check("R1 output", {31'd0, pwm}, 32'd0);
    check("R1 status", {30'd0, status}, 32'd0);
  endtask

  task automatic t_count_write_stopped;
    wr(2'd2, 32'h0000_1234);
    check("R2 stopped write", cnt, 32'h0000_1234);
    repeat (2) @(negedge clk);
    check("R11 idle hold", cnt, 32'h0000_1234);
  endtask

  task automatic t_setclr;
    wr(2'd0, 32'hFFFF_FFF8);
    wr(2'd1, 32'hFFFF_FFFA);
    wr(2'd3, 32'h9);
    check("R3 preload", cnt, 32'hFFFF_FFFE);
    check("R3 not yet active", {31'd0, pwm}, 32'd0);
    check("R13 running status", {30'd0, status}, 32'd1);
    @(negedge clk);
    check("R3 second cycle", cnt, ALL1);
    check("R3 still inactive", {31'd0, pwm}, 32'd0);
    @(negedge clk);
    check("R4 first reload", cnt, 32'hFFFF_FFF8);
    check("R3 first active", {31'd0, pwm}, 32'd1);
    check_sc(20, 32'hFFFF_FFF8, 32'hFFFF_FFFA, 1'b0);
  endtask

  task automatic t_count_write_running;
    logic [31:0] c;
    poll(32'hFFFF_FFF9);
    c = cnt;
    wr(2'd2, 32'h0);
    check("R2 running write ignored", cnt, c + 32'd1);
  endtask

  task automatic t_live_update;
    poll(32'hFFFF_FFF8);
    wr(2'd1, 32'hFFFF_FFFC);
    check_sc(6, 32'hFFFF_FFF8, 32'hFFFF_FFFC, 1'b0);   // R12 match immediate
    wr(2'd0, 32'hFFFF_FFF0);
    check_sc(24, 32'hFFFF_FFF0, 32'hFFFF_FFFC, 1'b0);  // R12 load at wrap
  endtask

  task automatic t_stop;
    logic [31:0] c;
    c = cnt;
    wr(2'd3, 32'h8);
    check("R11 frozen at once", cnt, c);
    check("R11 inactive", {31'd0, pwm}, 32'd0);
    check("R13 stopped status", {30'd0, status}, 32'd0);
    repeat (3) @(negedge clk);
    check("R11 still frozen", cnt, c);
  endtask

  task automatic t_invert;
    wr(2'd3, 32'hA);
    check("R13 inverted status", {30'd0, status}, 32'd2);
    check("R9 idle inverted", {31'd0, pwm}, 32'd1);
    wr(2'd0, 32'hFFFF_FFF8);
    wr(2'd1, 32'hFFFF_FFFA);
    wr(2'd3, 32'hB);
    check("R3 restart preload", cnt, 32'hFFFF_FFFE);
    check("R9 start inactive", {31'd0, pwm}, 32'd1);
    check_sc(20, 32'hFFFF_FFF8, 32'hFFFF_FFFA, 1'b1);
  endtask

  task automatic t_fields_locked;
    wr(2'd3, 32'h9);
    check("R10 inversion kept", {30'd0, status}, 32'd3);
    wr(2'd3, 32'h5);
    check("R10 status kept", {30'd0, status}, 32'd3);
    check_sc(12, 32'hFFFF_FFF8, 32'hFFFF_FFFA, 1'b1);
  endtask

  task automatic t_overlap;
    wr(2'd3, 32'h8);
    check("R10 stop only", {30'd0, status}, 32'd2);
    wr(2'd3, 32'h8);
    check("R9 normal idle", {31'd0, pwm}, 32'd0);
    wr(2'd0, 32'hFFFF_FFFC);
    wr(2'd1, ALL1);
    wr(2'd3, 32'h9);
    repeat (2) @(negedge clk);
    check("R6 reload", cnt, 32'hFFFF_FFFC);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R6 wrap wins", {31'd0, pwm}, 32'd1);
    end
  endtask

  task automatic t_toggle;
    logic lvl;
    wr(2'd3, 32'h8);
    wr(2'd0, 32'hFFFF_FFFA);
    wr(2'd1, 32'hFFFF_FFFC);
    wr(2'd3, 32'h5);
    lvl = 1'b0;
    check("R7 start level", {31'd0, pwm}, 32'd0);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] prev;
      prev = cnt;
      @(negedge clk);
      if (prev == ALL1) lvl = !lvl;
      check("R7 toggle", {31'd0, pwm}, {31'd0, lvl});
    end
  endtask

  task automatic t_off;
    wr(2'd3, 32'h0);
    wr(2'd3, 32'h1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check("R8 off level", {31'd0, pwm}, 32'd0);
    end
    check("R8 counter ran", {31'd0, cnt == 32'hFFFF_FFFE}, 32'd0);
  endtask

  initial begin
    rst_ni = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 32'd0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count_write_stopped();
    t_setclr();
    t_count_write_running();
    t_live_update();
    t_stop();
    t_invert();
    t_fields_locked();
    t_overlap();
    t_toggle();
    t_off();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule